// File: doc/BRIEF.md
# Serial Flash Direct Read Engine

This block turns a host read of the boot flash window into one read transaction on a serial flash. A request carries a 24-bit address, a byte count and two controls. The first control enables the low-memory segment alias. The second enables prefetch. The engine frames the transaction with an active-low chip select and drives the serial clock in mode 0 (clock idle low, data sampled on the rising edge). It shifts out the read opcode and the address most significant bit first, then collects the flash's reply one byte at a time. Each received byte comes out with a one-cycle strobe and its offset within the transaction.

Two request transformations happen before the transaction starts. Host reads that land in the 128 KB region just below 1 MB are redirected to the top of the flash by forcing the four high address bits to ones. When prefetch is enabled and the start address sits on a 64-byte boundary, the transaction is stretched to a full 64-byte burst. That burst always runs to completion once it has started. A host interface in front of this block presents the requests. It can then keep the bytes that come back as a read cache.

Top module: `spi_flash_rd_engine`

## Requirements
- R1: Every transaction begins with the opcode 8'h03, and the opcode and address are both shifted out most significant bit first. The serial clock is low whenever chip select is high, and MOSI changes only on falling clock edges.
- R2: The 24 address bits are sent as bits 23..0 right after the opcode, unchanged, when no alias applies. This holds even near 24'hFFFFFF; the flash wraps the address itself.
- R3: When the alias enable is high and the address lies in 24'h0E0000..24'h0FFFFF, the address sent has bits 23:20 forced to 4'hF. Addresses outside that region, or requests with the alias enable low, are sent unchanged.
- R4: When prefetch is enabled, the address bits 5:0 are zero, and the length is between 1 and 63, exactly 64 bytes are read. A length of 64 or more is read as requested.
- R5: When prefetch is disabled, or the start address is not 64-byte aligned, exactly the requested number of bytes is read.
- R6: Received bytes are delivered in order on rd_data with a one-cycle rd_valid strobe. rd_offset counts 0, 1, 2 and so on. Each byte is the flash content at the sent address plus its offset, modulo 2^24.
- R7: Chip select stays low from the first opcode bit through the last data bit. There are exactly 32 + 8·N rising clock edges while it is low, where N is the byte count. Chip select goes high again after the transaction.
- R8: busy is high from the cycle after a request is accepted until done pulses for one cycle. busy is low when done pulses. A request presented while busy is ignored.
- R9: A request with length zero produces a done pulse in the next cycle. It leaves busy low and causes no chip-select activity.
- R10: During and after reset the block is idle: cs_n is 1, sck is 0, and busy, done and rd_valid are all 0.
- R11: A prefetch burst that has started completes all 64 bytes, even if prefetch_en or the request inputs change while it runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, synchronously released |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_addr | input | 24 | Byte address of the read |
| req_len | input | LEN_W | Requested byte count |
| alias_en | input | 1 | Enables the low-memory segment redirect |
| prefetch_en | input | 1 | Enables the 64-byte aligned prefetch burst |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle completion pulse |
| rd_valid | output | 1 | Received byte strobe |
| rd_data | output | 8 | Received byte |
| rd_offset | output | LEN_W | Offset of the byte within the transaction |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock, mode 0 |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench builds the engine with HALF_DIV = 1, so each serial clock phase lasts one system clock, while LEN_W = 7 and BURST = 64 keep their defaults. With that setting a full 64-byte burst costs about 1100 cycles. The sweep can therefore cover every combination of prefetch on and off, four start offsets (aligned, one byte in, mid-block, last byte of a block) and lengths of 1, 3, 8, 64 and 65. The sweep checks every delivered byte against an arithmetic flash model. The legacy region edges, the top-of-flash address, zero-length requests and a burst disturbed while running are each checked as single cases.

// File: rtl/spi_rd_pkg.sv
package spi_rd_pkg;
  localparam int unsigned ADDR_W = 24;
  localparam int unsigned CMD_W  = 8 + ADDR_W;
  localparam logic [7:0] RD_OPCODE = 8'h03;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LEAD,
    ST_SHIFT,
    ST_TAIL,
    ST_GAP
  } eng_state_e;
endpackage

// File: rtl/spi_rd_planner.sv
// Request shaping: low-memory redirect and prefetch length stretch.
module spi_rd_planner
  import spi_rd_pkg::*;
#(
  parameter int unsigned LEN_W = 7,
  parameter int unsigned BURST = 64
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [LEN_W-1:0]  len_i,
  input  logic              alias_en_i,
  input  logic              prefetch_en_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [LEN_W-1:0]  len_o
);
  localparam int unsigned ALIGN_W = $clog2(BURST);
  localparam logic [6:0]  LEGACY_TAG = 7'b0000111; // bits 23:17 of 0E0000..0FFFFF

  logic in_legacy;
  logic aligned;
  logic stretch;

  always_comb begin
    in_legacy = alias_en_i && (addr_i[ADDR_W-1:17] == LEGACY_TAG);
    addr_o    = addr_i;
    if (in_legacy) begin
      addr_o[ADDR_W-1:20] = '1;
    end
    aligned = (addr_i[ALIGN_W-1:0] == '0);
    stretch = prefetch_en_i && aligned && (len_i != '0) && (len_i < LEN_W'(BURST));
    len_o   = stretch ? LEN_W'(BURST) : len_i;
  end
endmodule

// File: rtl/spi_rd_clkgen.sv
// Half-period tick generator for the serial clock.
module spi_rd_clkgen #(
  parameter int unsigned HALF_DIV = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic tick_o
);
  generate
    if (HALF_DIV <= 1) begin : g_full_rate
      assign tick_o = run_i;
    end else begin : g_divided
      localparam int unsigned DIV_W = $clog2(HALF_DIV);
      logic [DIV_W-1:0] cnt_q, cnt_d;
      logic             wrap;

      always_comb begin
        wrap  = (cnt_q == DIV_W'(HALF_DIV - 1));
        cnt_d = cnt_q;
        if (!run_i) begin
          cnt_d = '0;
        end else if (wrap) begin
          cnt_d = '0;
        end else begin
          cnt_d = cnt_q + 1'b1;
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else begin
          cnt_q <= cnt_d;
        end
      end

      assign tick_o = run_i && wrap;
    end
  endgenerate
endmodule

// File: rtl/spi_rd_shifter.sv
// Command shift-out and byte assembly of the reply.
module spi_rd_shifter
  import spi_rd_pkg::*;
#(
  parameter int unsigned OFF_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             shift_i,
  input  logic             sample_i,
  input  logic             data_phase_i,
  input  logic             miso_i,
  output logic             mosi_o,
  output logic             byte_valid_o,
  output logic [7:0]       byte_data_o,
  output logic [OFF_W-1:0] byte_offset_o
);
  logic [CMD_W-1:0] tx_q, tx_d;
  logic [6:0]       rx_q, rx_d;
  logic [2:0]       nbit_q, nbit_d;
  logic [OFF_W-1:0] nbyte_q, nbyte_d;
  logic             vld_q, vld_d;
  logic [7:0]       dat_q, dat_d;
  logic [OFF_W-1:0] off_q, off_d;

  always_comb begin
    tx_d    = tx_q;
    rx_d    = rx_q;
    nbit_d  = nbit_q;
    nbyte_d = nbyte_q;
    vld_d   = 1'b0;
    dat_d   = dat_q;
    off_d   = off_q;
    if (load_i) begin
      tx_d    = cmd_i;
      nbit_d  = '0;
      nbyte_d = '0;
    end else begin
      if (shift_i) begin
        tx_d = {tx_q[CMD_W-2:0], 1'b0};
      end
      if (sample_i && data_phase_i) begin
        rx_d   = {rx_q[5:0], miso_i};
        nbit_d = nbit_q + 1'b1;
        if (nbit_q == 3'd7) begin
          vld_d   = 1'b1;
          dat_d   = {rx_q, miso_i};
          off_d   = nbyte_q;
          nbyte_d = nbyte_q + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_q    <= '0;
      rx_q    <= '0;
      nbit_q  <= '0;
      nbyte_q <= '0;
      vld_q   <= 1'b0;
      dat_q   <= '0;
      off_q   <= '0;
    end else begin
      tx_q    <= tx_d;
      rx_q    <= rx_d;
      nbit_q  <= nbit_d;
      nbyte_q <= nbyte_d;
      vld_q   <= vld_d;
      dat_q   <= dat_d;
      off_q   <= off_d;
    end
  end

  assign mosi_o        = tx_q[CMD_W-1];
  assign byte_valid_o  = vld_q;
  assign byte_data_o   = dat_q;
  assign byte_offset_o = off_q;
endmodule

// File: rtl/spi_flash_rd_engine.sv
// Direct read engine for a serial boot flash.
module spi_flash_rd_engine
  import spi_rd_pkg::*;
#(
  parameter int unsigned LEN_W    = 7,
  parameter int unsigned BURST    = 64,
  parameter int unsigned HALF_DIV = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [23:0]       req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic              alias_en,
  input  logic              prefetch_en,
  output logic              busy,
  output logic              done,
  output logic              rd_valid,
  output logic [7:0]        rd_data,
  output logic [LEN_W-1:0]  rd_offset,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  localparam int unsigned BIT_W = LEN_W + 4;

  eng_state_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic              done_q, done_d;
  logic [BIT_W-1:0]  bit_cnt_q, bit_cnt_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic [BIT_W-1:0]  last_bit;
  logic              data_phase;

  logic [ADDR_W-1:0] plan_addr;
  logic [LEN_W-1:0]  plan_len;
  logic              tick;
  logic              load, shift, sample;

  spi_rd_planner #(.LEN_W(LEN_W), .BURST(BURST)) u_plan (
    .addr_i       (req_addr),
    .len_i        (req_len),
    .alias_en_i   (alias_en),
    .prefetch_en_i(prefetch_en),
    .addr_o       (plan_addr),
    .len_o        (plan_len)
  );

  spi_rd_clkgen #(.HALF_DIV(HALF_DIV)) u_clk (
    .clk   (clk),
    .rst_n (rst_n),
    .run_i (state_q != ST_IDLE),
    .tick_o(tick)
  );

  spi_rd_shifter #(.OFF_W(LEN_W)) u_shf (
    .clk          (clk),
    .rst_n        (rst_n),
    .load_i       (load),
    .cmd_i        ({RD_OPCODE, plan_addr}),
    .shift_i      (shift),
    .sample_i     (sample),
    .data_phase_i (data_phase),
    .miso_i       (spi_miso),
    .mosi_o       (spi_mosi),
    .byte_valid_o (rd_valid),
    .byte_data_o  (rd_data),
    .byte_offset_o(rd_offset)
  );

  assign last_bit   = {1'b0, len_q, 3'b000} + BIT_W'(CMD_W - 1);
  assign data_phase = (bit_cnt_q >= BIT_W'(CMD_W));

  always_comb begin
    state_d   = state_q;
    sck_d     = sck_q;
    cs_n_d    = cs_n_q;
    bit_cnt_d = bit_cnt_q;
    len_d     = len_q;
    done_d    = 1'b0;
    load      = 1'b0;
    shift     = 1'b0;
    sample    = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (plan_len == '0) begin
            done_d = 1'b1;
          end else begin
            state_d   = ST_LEAD;
            cs_n_d    = 1'b0;
            bit_cnt_d = '0;
            len_d     = plan_len;
            load      = 1'b1;
          end
        end
      end
      ST_LEAD: begin
        if (tick) begin
          sck_d   = 1'b1;
          sample  = 1'b1;
          state_d = ST_SHIFT;
        end
      end
      ST_SHIFT: begin
        if (tick) begin
          if (sck_q) begin
            sck_d = 1'b0;
            if (bit_cnt_q == last_bit) begin
              state_d = ST_TAIL;
            end else begin
              bit_cnt_d = bit_cnt_q + 1'b1;
              shift     = 1'b1;
            end
          end else begin
            sck_d  = 1'b1;
            sample = 1'b1;
          end
        end
      end
      ST_TAIL: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          state_d = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tick) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      sck_q     <= 1'b0;
      cs_n_q    <= 1'b1;
      done_q    <= 1'b0;
      bit_cnt_q <= '0;
      len_q     <= '0;
    end else begin
      state_q   <= state_d;
      sck_q     <= sck_d;
      cs_n_q    <= cs_n_d;
      done_q    <= done_d;
      bit_cnt_q <= bit_cnt_d;
      len_q     <= len_d;
    end
  end

  assign busy     = (state_q != ST_IDLE);
  assign done     = done_q;
  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;

  // Checker-only byte counter for the burst-length property.
  logic [LEN_W-1:0] chk_bytes_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chk_bytes_q <= '0;
    end else if (load) begin
      chk_bytes_q <= '0;
    end else if (rd_valid) begin
      chk_bytes_q <= chk_bytes_q + 1'b1;
    end
  end

  assert_sck_low_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_sck) |-> $stable(spi_mosi));

  assert_done_not_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_byte_inside_txn_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> (busy && !spi_cs_n));

  assert_burst_complete_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GAP) |-> (chk_bytes_q == len_q));
endmodule

// File: tb/spi_flash_rd_engine_test.sv
`timescale 1ns/1ps
module spi_flash_rd_engine_test;
  localparam int LEN_W = 7;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             req_valid;
  logic [23:0]      req_addr;
  logic [LEN_W-1:0] req_len;
  logic             alias_en;
  logic             prefetch_en;
  logic             busy, done, rd_valid;
  logic [7:0]       rd_data;
  logic [LEN_W-1:0] rd_offset;
  logic             spi_cs_n, spi_sck, spi_mosi;
  logic             spi_miso;

  int n_tests = 0;
  int n_fail  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spi_flash_rd_engine #(.LEN_W(LEN_W), .BURST(64), .HALF_DIV(1)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_len(req_len), .alias_en(alias_en), .prefetch_en(prefetch_en),
    .busy(busy), .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .rd_offset(rd_offset), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  function automatic logic [7:0] fdata(input logic [23:0] a);
    return a[7:0] ^ a[15:8] ^ {a[19:16], a[23:20]} ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // Flash model
  int          s_txn = 0;
  int          s_seen = 0;
  int          s_bits = 0;
  int          s_stray = 0;
  logic [31:0] s_sh;
  logic [31:0] cap_word = '0;

  always @(negedge spi_cs_n) s_txn++;

  always @(posedge spi_sck) begin
    if (spi_cs_n) begin
      s_stray++;
    end else begin
      if (s_seen != s_txn) begin
        s_seen = s_txn;
        s_bits = 0;
        s_sh   = '0;
      end
      s_sh = {s_sh[30:0], spi_mosi};
      s_bits++;
      if (s_bits == 32) cap_word = s_sh;
    end
  end

  always @(negedge spi_sck) begin
    if (!spi_cs_n && s_bits >= 32) begin
      int idx;
      logic [23:0] a;
      logic [7:0]  b;
      idx = s_bits - 32;
      a = cap_word[23:0] + 24'(idx / 8);
      b = fdata(a);
      spi_miso <= b[7 - (idx % 8)];
    end
  end

  // Byte monitor (R6)
  int          byte_total = 0;
  int          mon_start = 0;
  logic [23:0] mon_base = '0;

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      int k;
      k = byte_total - mon_start;
      chk(rd_offset == LEN_W'(k), "R6", "byte offset", rd_offset, k);
      chk(rd_data == fdata(mon_base + 24'(k)), "R6", "byte data",
          rd_data, fdata(mon_base + 24'(k)));
      byte_total++;
    end
  end

  task automatic run_req(input logic [23:0] a, input int len, input bit al,
                         input bit pf, input bit disturb);
    logic [23:0] ea;
    int el, t0, cyc;
    string lrq;
    ea = (al && a >= 24'h0E0000 && a <= 24'h0FFFFF) ? {4'hF, a[19:0]} : a;
    el = (pf && a[5:0] == 6'd0 && len != 0 && len < 64) ? 64 : len;
    lrq = disturb ? "R11" : ((el != len) ? "R4" : "R5");
    t0 = s_txn;
    @(negedge clk);
    mon_base  = ea;
    mon_start = byte_total;
    req_addr = a; req_len = LEN_W'(len); alias_en = al; prefetch_en = pf;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (len == 0) begin
      chk(done == 1'b1 && busy == 1'b0, "R9", "zero-length done/busy",
          {done, busy}, 2'b10);
      repeat (4) @(negedge clk);
      chk(s_txn == t0 && spi_cs_n == 1'b1, "R9", "zero-length cs activity",
          s_txn - t0, 0);
      return;
    end
    chk(busy == 1'b1 && done == 1'b0, "R8", "busy after accept", {busy, done}, 2'b10);
    if (disturb) begin
      repeat (40) @(negedge clk);
      prefetch_en = 1'b0; req_addr = 24'h123456; req_len = 1; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
    end
    cyc = 0;
    while (!done && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done == 1'b1, "R8", "done reached", done, 1);
    chk(busy == 1'b0, "R8", "busy low at done", busy, 0);
    chk(cap_word[31:24] == 8'h03, "R1", "opcode", cap_word[31:24], 8'h03);
    chk(cap_word[23:0] == ea, al ? "R3" : "R2", "address sent", cap_word[23:0], ea);
    chk(byte_total - mon_start == el, lrq, "byte count", byte_total - mon_start, el);
    chk(s_bits == 32 + 8 * el, "R7", "clocks under cs", s_bits, 32 + 8 * el);
    chk(s_txn == t0 + 1, disturb ? "R8" : "R7", "transactions", s_txn - t0, 1);
    @(negedge clk);
    chk(spi_cs_n == 1'b1 && spi_sck == 1'b0 && done == 1'b0, "R7", "idle after done",
        {spi_cs_n, spi_sck, done}, 3'b100);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    int offs[4];
    int lens[5];
    offs = '{0, 1, 32, 63};
    lens = '{1, 3, 8, 64, 65};
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_len = '0;
    alias_en = 1'b0; prefetch_en = 1'b0; spi_miso = 1'b0;
    repeat (3) @(negedge clk);
    chk({spi_cs_n, spi_sck, busy, done, rd_valid} == 5'b10000, "R10", "in reset",
        {spi_cs_n, spi_sck, busy, done, rd_valid}, 5'b10000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk({spi_cs_n, spi_sck, busy, done, rd_valid} == 5'b10000, "R10", "after reset",
        {spi_cs_n, spi_sck, busy, done, rd_valid}, 5'b10000);

    for (int p = 0; p < 2; p++)
      for (int o = 0; o < 4; o++)
        for (int l = 0; l < 5; l++)
          run_req(24'h7C0000 + 24'(lens[l] << 8) + 24'(p << 14) + 24'(offs[o]),
                  lens[l], 1'b0, p[0], 1'b0);

    run_req(24'h0E0000, 4, 1'b1, 1'b0, 1'b0);
    run_req(24'h0FFFC0, 2, 1'b1, 1'b1, 1'b0);
    run_req(24'h0DFFFF, 2, 1'b1, 1'b0, 1'b0);
    run_req(24'h0F1234, 3, 1'b0, 1'b0, 1'b0);
    run_req(24'h1E0000, 2, 1'b1, 1'b0, 1'b0);
    run_req(24'hFFFFFE, 4, 1'b0, 1'b0, 1'b0);
    run_req(24'h000040, 0, 1'b0, 1'b1, 1'b0);
    run_req(24'h000003, 0, 1'b0, 1'b0, 1'b0);
    run_req(24'h2A0000, 4, 1'b0, 1'b1, 1'b1);

    chk(s_stray == 0, "R7", "clock edges outside cs", s_stray, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule